// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block collects 32 level-sensitive interrupt request lines into a single interrupt output toward a parent controller or CPU. Every line holds two bits of state: a latched level and an enable. A line whose level and enable are both set counts as pending. A line that is raised but not enabled stays latched and silent until software enables it.

Software uses a small 32-bit register bus. It can read the number of pending lines as a count from 0 to 32, or read the lowest-numbered pending line. It can drop every latched level at once; this does not touch the enables. It can also mask or unmask one line by writing that line's number. The parent output is high whenever any line is pending. Priority is by lowest index only, and every line is level-sensitive.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous reset, every latched level and every enable is 0, the parent output is low, and both readable registers return 0.
- R2: A line's level bit is set on the clock edge that samples its source high after it was sampled low. It is cleared on the edge that samples its source low.
- R3: A read of offset 0x00 returns the number of pending lines, the whole range 0 to 32, in the low bits of the read data.
- R4: A read of offset 0x04 returns the index of the lowest-numbered pending line, or 0 when no line is pending.
- R5: Any write to offset 0x08 clears every latched level, including those of masked lines, and leaves every enable unchanged. A line whose source stays high stays cleared until its source falls and rises again.
- R6: A write of value k to offset 0x0c clears the enable of line k. A write of k to offset 0x10 sets it. The change takes effect on the clock edge of the write.
- R7: A write to offset 0x0c or 0x10 with a value of 32 or more changes no enable.
- R8: The parent output is high exactly when at least one line has level 1 and enable 1.
- R9: Unmasking a line whose level is already latched makes it pending, and raises the parent output, on the edge of the write.
- R10: Read data is combinational and reflects the state of the read cycle. It is 0 when the read strobe is low or the offset is not 0x00 or 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Request lines, one bit per line, synchronous to clk |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Parent interrupt output |

## Verification
The bench first raises a line while it is masked and then unmasks it. This separates latch-then-enable behaviour from gating the source straight through. Overlapping lines that then drop one at a time show whether the lowest-index read tracks the level or a stale value. Disable and enable writes with values 32 and above catch a decoder that only looks at the low five bits. A clear-all while a source stays high, followed by a fresh edge on that source, shows both that levels were cleared and that enables survived. With all 32 lines pending, the count must read 32, which exposes a count register one bit too narrow.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_LINES = 32;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFS_COUNT  = 8'h00,
        OFS_LOWEST = 8'h04,
        OFS_FLUSH  = 8'h08,
        OFS_MASK   = 8'h0C,
        OFS_UNMASK = 8'h10
    } reg_ofs_e;

    typedef struct packed {
        logic flush;
        logic mask;
        logic unmask;
    } bus_cmd_t;

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
    import irqc_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int CNT_W  = $clog2(N_LINES + 1)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [CNT_W-1:0]  pend_cnt_i,
    input  logic [IDX_W-1:0]  low_idx_i,
    output bus_cmd_t          cmd_o,
    output logic [IDX_W-1:0]  line_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic in_range;

    always_comb begin
        in_range     = (wdata_i < DATA_W'(N_LINES));
        line_o       = wdata_i[IDX_W-1:0];
        cmd_o.flush  = wr_i && (addr_i == OFS_FLUSH);
        cmd_o.mask   = wr_i && (addr_i == OFS_MASK) && in_range;
        cmd_o.unmask = wr_i && (addr_i == OFS_UNMASK) && in_range;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (addr_i == OFS_COUNT)
                rdata_o = DATA_W'(pend_cnt_i);
            else if (addr_i == OFS_LOWEST)
                rdata_o = DATA_W'(low_idx_i);
        end
    end

endmodule

// File: rtl/irqc_line_bank.sv
module irqc_line_bank
    import irqc_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] src_i,
    input  bus_cmd_t           cmd_i,
    input  logic [IDX_W-1:0]   line_i,
    output logic [N_LINES-1:0] pend_o
);

    logic [N_LINES-1:0] src_q;
    logic [N_LINES-1:0] lvl_q;
    logic [N_LINES-1:0] en_q;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic rise;
        logic hit;
        assign rise = src_i[g] & ~src_q[g];
        assign hit  = (line_i == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[g] <= 1'b0;
                lvl_q[g] <= 1'b0;
                en_q[g]  <= 1'b0;
            end else begin
                src_q[g] <= src_i[g];
                lvl_q[g] <= ~cmd_i.flush & src_i[g] & (lvl_q[g] | rise);
                if (cmd_i.unmask && hit)
                    en_q[g] <= 1'b1;
                else if (cmd_i.mask && hit)
                    en_q[g] <= 1'b0;
            end
        end
    end

    assign pend_o = lvl_q & en_q;

    // R2: a latched level requires the source to have been high on that edge
    assert_level_needs_src_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lvl_q & ~$past(src_i)) == '0));

    // R5: clear-all drops every level
    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_i.flush |=> (lvl_q == '0));

    // R5: clear-all alone leaves enables untouched
    assert_flush_keeps_en_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.flush && !cmd_i.mask && !cmd_i.unmask) |=> $stable(en_q));

    // R7: out-of-range writes never alter enables (decoder drops them)
    assert_range_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.mask && !cmd_i.unmask) |=> $stable(en_q));

    // R9: unmasking a latched line with its source held makes it pending
    assert_unmask_latched_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.unmask && !cmd_i.flush && lvl_q[line_i] && src_i[line_i])
        |=> pend_o[$past(line_i)]);

endmodule

// File: rtl/irqc_pending_reduce.sv
module irqc_pending_reduce
    import irqc_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int CNT_W  = $clog2(N_LINES + 1)
) (
    input  logic [N_LINES-1:0] pend_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [IDX_W-1:0]   low_idx_o,
    output logic               any_o
);

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N_LINES; i++)
            cnt_o = cnt_o + CNT_W'(pend_i[i]);
    end

    always_comb begin
        low_idx_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--)
            if (pend_i[i])
                low_idx_o = IDX_W'(i);
    end

    assign any_o = |pend_i;

    // R4: no pending line means the lowest index reads 0
    always_comb begin
        assert_idx_idle_R4: assert (cnt_o != '0 || low_idx_o == '0);
    end

    // R4: the reported index is itself pending
    always_comb begin
        assert_idx_pending_R4: assert (!any_o || pend_i[low_idx_o]);
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int CNT_W  = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    input  logic               bus_rd_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);

    bus_cmd_t           cmd;
    logic [IDX_W-1:0]   line;
    logic [N_LINES-1:0] pend;
    logic [CNT_W-1:0]   pend_cnt;
    logic [IDX_W-1:0]   low_idx;
    logic               any_pend;

    irqc_bus_decode #(.N_LINES(N_LINES)) u_decode (
        .addr_i     (bus_addr_i),
        .wr_i       (bus_wr_i),
        .wdata_i    (bus_wdata_i),
        .rd_i       (bus_rd_i),
        .pend_cnt_i (pend_cnt),
        .low_idx_i  (low_idx),
        .cmd_o      (cmd),
        .line_o     (line),
        .rdata_o    (bus_rdata_o)
    );

    irqc_line_bank #(.N_LINES(N_LINES)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .src_i  (irq_src_i),
        .cmd_i  (cmd),
        .line_i (line),
        .pend_o (pend)
    );

    irqc_pending_reduce #(.N_LINES(N_LINES)) u_reduce (
        .pend_i    (pend),
        .cnt_o     (pend_cnt),
        .low_idx_o (low_idx),
        .any_o     (any_pend)
    );

    assign irq_o = any_pend;

    // R8: parent output agrees with the pending count
    assert_irq_matches_cnt_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o == (pend_cnt != '0));

    // R1: out of reset nothing is pending
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (pend_cnt == '0 && !irq_o));

    // R3: count never exceeds the number of lines
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CNT_W'(N_LINES));

endmodule

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [31:0] m_lvl = '0;
    logic [31:0] m_en = '0;
    logic [31:0] m_srcq = '0;

    always #2 clk = ~clk;

    irq_cascade_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .irq_src_i   (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_lvl = '0; m_en = '0; m_srcq = '0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (wr && addr == 8'h08) m_lvl[i] = 1'b0;
                else if (!src[i]) m_lvl[i] = 1'b0;
                else if (!m_srcq[i]) m_lvl[i] = 1'b1;
            end
            m_srcq = src;
            if (wr && addr == 8'h0C && wdata < 32) m_en[wdata[4:0]] = 1'b0;
            if (wr && addr == 8'h10 && wdata < 32) m_en[wdata[4:0]] = 1'b1;
        end
    end

    function automatic int model_count();
        int c = 0;
        for (int i = 0; i < 32; i++) if (m_lvl[i] && m_en[i]) c++;
        return c;
    endfunction

    function automatic int model_lowest();
        for (int i = 0; i < 32; i++) if (m_lvl[i] && m_en[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] model_rdata();
        if (!rd) return 32'd0;
        if (addr == 8'h00) return 32'(model_count());
        if (addr == 8'h04) return 32'(model_lowest());
        return 32'd0;
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (irq !== (model_count() != 0)) begin
                errors++;
                $display("FAIL R8 cycle %0d irq actual %0b expected %0b", cycles, irq, model_count() != 0);
            end
            checks++;
            if (rdata !== model_rdata()) begin
                errors++;
                $display("FAIL R10 cycle %0d rdata actual %0d expected %0d", cycles, rdata, model_rdata());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk); #1;
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        rd = 1'b0; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk); #1;
        wr = 1'b0; rd = 1'b0; src = v;
        @(negedge clk); #1;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        wr = 1'b0; rd = 1'b1; addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%0h actual %0d expected %0d", tag, a, rdata, exp);
        end
        @(negedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic irq_check(input logic exp, input string tag);
        @(negedge clk); #1;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        step();
        // R1: reset state
        irq_check(1'b0, "R1");
        read_check(8'h00, 32'd0, "R1");
        read_check(8'h04, 32'd0, "R1");

        // R9: line 5 raised while masked stays silent, then unmasked
        set_src(32'h0000_0020);
        read_check(8'h00, 32'd0, "R9");
        irq_check(1'b0, "R9");
        bus_write(8'h10, 32'd5);
        irq_check(1'b1, "R9");
        read_check(8'h00, 32'd1, "R9");
        read_check(8'h04, 32'd5, "R6");

        // R4: lower line joins, lowest index follows
        bus_write(8'h10, 32'd3);
        set_src(32'h0000_0028);
        read_check(8'h04, 32'd3, "R4");
        read_check(8'h00, 32'd2, "R3");
        // R2: source low clears the level
        set_src(32'h0000_0020);
        read_check(8'h04, 32'd5, "R2");
        read_check(8'h00, 32'd1, "R2");

        // R7: out-of-range writes aliasing lines 5 and 8
        bus_write(8'h0C, 32'd37);
        read_check(8'h00, 32'd1, "R7");
        set_src(32'h0000_0120);
        bus_write(8'h10, 32'd40);
        read_check(8'h00, 32'd1, "R7");

        // R6: mask line 5
        bus_write(8'h0C, 32'd5);
        read_check(8'h00, 32'd0, "R6");
        irq_check(1'b0, "R8");

        // R5: clear-all with sources held, then unmask line 5
        bus_write(8'h08, 32'd0);
        bus_write(8'h10, 32'd5);
        read_check(8'h00, 32'd0, "R5");
        irq_check(1'b0, "R5");
        set_src(32'h0000_0000);
        set_src(32'h0000_0020);
        read_check(8'h00, 32'd1, "R5");
        read_check(8'h04, 32'd5, "R5");

        // R3: all lines pending
        for (int i = 0; i < 32; i++) bus_write(8'h10, 32'(i));
        set_src(32'h0000_0000);
        set_src(32'hFFFF_FFFF);
        read_check(8'h00, 32'd32, "R3");
        read_check(8'h04, 32'd0, "R4");
        irq_check(1'b1, "R8");

        // R5: clear-all drops everything, enables stay set
        bus_write(8'h08, 32'hDEAD_BEEF);
        read_check(8'h00, 32'd0, "R5");
        irq_check(1'b0, "R8");
        set_src(32'h0000_0000);
        set_src(32'h8000_0000);
        read_check(8'h04, 32'd31, "R5");

        // R10: no strobe or unmapped offset reads zero
        @(negedge clk); #1; rd = 1'b0; addr = 8'h00; #1;
        checks++;
        if (rdata !== 32'd0) begin
            errors++;
            $display("FAIL R10 idle read actual %0d expected 0", rdata);
        end
        read_check(8'h14, 32'd0, "R10");

        step();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule